// File: doc/BRIEF.md
# Register-Pair Swizzle Move Unit

This execution unit carries out a lane-permuting move between 64-bit register pairs. A 32-bit instruction word names an even source pair and an even destination pair. The two source registers together hold four 32-bit lanes, called X, Y, Z and W. Each of the four destination lane slots takes one of these lanes, a small constant, or nothing. Slots that receive nothing are handled in one of two ways. They keep their old contents when the source and destination pair numbers are equal. They are cleared when the two numbers differ. The unit contains the 32 x 64-bit register file it operates on, with one write enable per 32-bit half.

Instructions arrive on a valid/ready port, and a transfer happens on a rising edge where `issue_valid` and `issue_ready` are both high. The source lanes are sampled on that accepting edge, and the result is captured in a writeback register. The register file is updated on the next rising edge. Back-pressure is simple: `issue_ready` is low for the one cycle while a writeback is pending, and also in any cycle where the load port is in use. A word held valid while ready is low is not taken, and it may stay on the port until ready returns.

A direct load port writes whole registers, so the surrounding pipeline (or a bench) can seed values. A combinational read port exposes any register. Words that break the encoding rules raise a one-cycle illegal flag, and nothing is written for them.

Top module: `swz_move_unit`

## Requirements
- R1: After reset, every register reads zero on `rd_data`, `illegal_o` is low, and `issue_ready` is high.
- R2: Instruction fields are taken from the word as follows: `issue_insn[31:26]` primary opcode, `[25:21]` destination register RT, `[20:16]` source register RS, `[15:4]` immediate, `[3:0]` sub-opcode. The immediate holds four 3-bit selectors: `[15:13]` drives slot 0 (bits 31:0 of RT), `[12:10]` slot 1 (bits 63:32 of RT), `[9:7]` slot 2 (bits 31:0 of RT+1), `[6:4]` slot 3 (bits 63:32 of RT+1). Selector values 0, 1, 2 and 3 pick X (RS bits 31:0), Y (RS bits 63:32), Z (RS+1 bits 31:0) and W (RS+1 bits 63:32).
- R3: Selector 4 writes 0x00000000 into its slot, and selector 5 writes 0x00000001.
- R4: When RT equals RS, a slot with selector 7 keeps its previous contents. Every lane is read before any slot is written, so a permutation sees the old values.
- R5: When RT differs from RS, a slot with selector 7 is written with zero, and the source pair is left unchanged.
- R6: A word is accepted on a rising edge where `issue_valid` and `issue_ready` are both high. `issue_ready` is low during the following cycle and during any cycle where `ld_en` is high. The result is visible on `rd_data` after the second rising edge counted from acceptance.
- R7: An odd RT or an odd RS raises `illegal_o` for exactly the cycle after acceptance, and no register changes.
- R8: Selector value 6 in any slot raises `illegal_o`, and no register changes.
- R9: The primary opcode must equal the OPCODE parameter (default 22), and the sub-opcode must be 4'b0011 or 4'b1011, otherwise `illegal_o` is raised and nothing is written. The two accepted sub-opcodes produce the same bit-level result.
- R10: `ld_en` writes all 64 bits of `ld_data` into register `ld_addr` on the rising edge. This load takes priority over a writeback to the same register on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction word present |
| issue_ready | output | 1 | Unit can take a word this cycle |
| issue_insn | input | 32 | Instruction word |
| ld_en | input | 1 | Direct register load strobe |
| ld_addr | input | 5 | Register written by the load |
| ld_data | input | 64 | Value written by the load |
| rd_addr | input | 5 | Register shown on rd_data |
| rd_data | output | 64 | Current contents of register rd_addr |
| illegal_o | output | 1 | One-cycle flag for a rejected word |

## Verification
The sweep runs every one of the 4096 immediates twice. One run is in place, and the other uses distinct pairs preloaded with different values. This separates the keep rule from the zero-fill rule, exposes any swapped selector-to-slot or lane-to-half mapping, and covers each constant and the reserved code in every slot. The float and integer sub-opcodes alternate through the sweep, which shows that the two produce the same result. Single cases then cover odd register numbers, a wrong sub-opcode and a wrong primary opcode, the back-pressure from the load port, and a load that collides with a pending writeback. In each of these the bench shows that nothing else was written.

// File: rtl/swz_pkg.sv
package swz_pkg;
  localparam int REG_W  = 5;
  localparam int NREGS  = 1 << REG_W;
  localparam int NSLOT  = 4;
  localparam int SEL_W  = 3;
  localparam int IMM_W  = NSLOT * SEL_W;

  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t SEL_ZERO = 3'd4;
  localparam sel_t SEL_ONE  = 3'd5;
  localparam sel_t SEL_RSVD = 3'd6;
  localparam sel_t SEL_SKIP = 3'd7;

  localparam logic [3:0] SUB_INT = 4'b0011;
  localparam logic [3:0] SUB_FLT = 4'b1011;
endpackage

// File: rtl/swz_decode.sv
module swz_decode
  import swz_pkg::*;
#(
  parameter logic [5:0] OPCODE = 6'd22
) (
  input  logic [31:0]               insn,
  output logic [REG_W-2:0]          rt_pair,
  output logic [REG_W-2:0]          rs_pair,
  output sel_t [NSLOT-1:0]          sel,
  output logic                      inplace,
  output logic                      illegal
);
  logic [5:0]       prim;
  logic [REG_W-1:0] rt, rs;
  logic [IMM_W-1:0] imm;
  logic [3:0]       sub;
  logic [NSLOT-1:0] rsvd;

  assign prim = insn[31:26];
  assign rt   = insn[25:21];
  assign rs   = insn[20:16];
  assign imm  = insn[15:4];
  assign sub  = insn[3:0];

  // slot 0 (lowest destination half) takes the most significant selector
  for (genvar s = 0; s < NSLOT; s++) begin : g_sel
    assign sel[s]  = imm[(NSLOT-1-s)*SEL_W +: SEL_W];
    assign rsvd[s] = (sel[s] == SEL_RSVD);
  end

  assign rt_pair = rt[REG_W-1:1];
  assign rs_pair = rs[REG_W-1:1];
  assign inplace = (rt == rs);
  assign illegal = (prim != OPCODE) || !((sub == SUB_INT) || (sub == SUB_FLT))
                 || rt[0] || rs[0] || (|rsvd);
endmodule

// File: rtl/swz_lane_xbar.sv
module swz_lane_xbar
  import swz_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic [NSLOT-1:0][LANE_W-1:0] src,
  input  sel_t [NSLOT-1:0]             sel,
  input  logic                         inplace,
  output logic [NSLOT-1:0][LANE_W-1:0] dst,
  output logic [NSLOT-1:0]             we
);
  localparam logic [LANE_W-1:0] ONE_VAL = LANE_W'(1);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_comb begin
      dst[s] = '0;
      we[s]  = 1'b1;
      case (sel[s])
        3'd0, 3'd1, 3'd2, 3'd3: dst[s] = src[sel[s][1:0]];
        SEL_ZERO:               dst[s] = '0;
        SEL_ONE:                dst[s] = ONE_VAL;
        default:                we[s]  = !inplace;  // untargeted: keep or clear
      endcase
    end
  end
endmodule

// File: rtl/swz_regfile.sv
module swz_regfile
  import swz_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wb_vld,
  input  logic [REG_W-2:0]             wb_pair,
  input  logic [NSLOT-1:0]             wb_we,
  input  logic [NSLOT-1:0][LANE_W-1:0] wb_data,
  input  logic                         ld_en,
  input  logic [REG_W-1:0]             ld_addr,
  input  logic [2*LANE_W-1:0]          ld_data,
  input  logic [REG_W-2:0]             src_pair,
  output logic [NSLOT-1:0][LANE_W-1:0] src_lanes,
  input  logic [REG_W-1:0]             rd_addr,
  output logic [2*LANE_W-1:0]          rd_data
);
  logic [LANE_W-1:0] mem [NREGS][2];

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREGS; r++) begin
      for (int h = 0; h < 2; h++) begin
        if (!rst_n)
          mem[r][h] <= '0;
        else if (ld_en && ld_addr == REG_W'(r))
          mem[r][h] <= ld_data[h*LANE_W +: LANE_W];
        else if (wb_vld && wb_pair == (REG_W-1)'(r/2) && wb_we[(r%2)*2+h])
          mem[r][h] <= wb_data[(r%2)*2+h];
      end
    end
  end

  // lane k lives in register (pair*2 + k/2), half k%2
  for (genvar k = 0; k < NSLOT; k++) begin : g_src
    assign src_lanes[k] = mem[{src_pair, 1'(k/2)}][k%2];
  end

  assign rd_data = {mem[rd_addr][1], mem[rd_addr][0]};

  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> ({mem[$past(ld_addr)][1], mem[$past(ld_addr)][0]} == $past(ld_data)));
endmodule

// File: rtl/swz_move_unit.sv
module swz_move_unit
  import swz_pkg::*;
#(
  parameter int         LANE_W = 32,
  parameter logic [5:0] OPCODE = 6'd22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_valid,
  output logic                issue_ready,
  input  logic [31:0]         issue_insn,
  input  logic                ld_en,
  input  logic [REG_W-1:0]    ld_addr,
  input  logic [2*LANE_W-1:0] ld_data,
  input  logic [REG_W-1:0]    rd_addr,
  output logic [2*LANE_W-1:0] rd_data,
  output logic                illegal_o
);
  logic [REG_W-2:0]             rt_pair, rs_pair;
  sel_t [NSLOT-1:0]             sel;
  logic                         inplace, dec_ill, acc;
  logic [NSLOT-1:0][LANE_W-1:0] src_lanes, x_dst, wb_data;
  logic [NSLOT-1:0]             x_we, wb_we;
  logic                         wb_vld, wb_ill;
  logic [REG_W-2:0]             wb_pair;

  assign issue_ready = !wb_vld && !ld_en;
  assign acc         = issue_valid && issue_ready;

  swz_decode #(.OPCODE(OPCODE)) u_dec (
    .insn(issue_insn), .rt_pair(rt_pair), .rs_pair(rs_pair),
    .sel(sel), .inplace(inplace), .illegal(dec_ill)
  );

  swz_lane_xbar #(.LANE_W(LANE_W)) u_xbar (
    .src(src_lanes), .sel(sel), .inplace(inplace), .dst(x_dst), .we(x_we)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_vld  <= 1'b0;
      wb_ill  <= 1'b0;
      wb_pair <= '0;
      wb_we   <= '0;
      wb_data <= '0;
    end else begin
      wb_vld  <= acc;
      wb_ill  <= acc && dec_ill;
      wb_pair <= rt_pair;
      wb_we   <= (acc && !dec_ill) ? x_we : '0;
      wb_data <= x_dst;
    end
  end

  assign illegal_o = wb_ill;

  swz_regfile #(.LANE_W(LANE_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wb_vld(wb_vld), .wb_pair(wb_pair), .wb_we(wb_we), .wb_data(wb_data),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .src_pair(rs_pair), .src_lanes(src_lanes),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !issue_ready);

  a_r7_odd_reg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (issue_insn[21] || issue_insn[16])) |=> illegal_o);

  a_r9_bad_subop: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && issue_insn[3:0] != SUB_INT && issue_insn[3:0] != SUB_FLT) |=> illegal_o);

  a_r7_illegal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> !illegal_o);
endmodule

// File: tb/sim_swz_move_unit.sv
`timescale 1ns/1ps
module sim_swz_move_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [31:0] issue_insn = '0;
  logic        ld_en = 1'b0;
  logic [4:0]  ld_addr = '0;
  logic [63:0] ld_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [63:0] rd_data;
  logic        illegal_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  swz_move_unit u0 (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_insn(issue_insn), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [63:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic load(input logic [4:0] a, input logic [63:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(posedge clk); @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w, output logic ill);
    issue_valid = 1'b1; issue_insn = w;
    #1 chk("R6 ready before accept", 64'(issue_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    issue_valid = 1'b0;
    #1 chk("R6 ready while pending", 64'(issue_ready), 64'd0);
    ill = illegal_o;
    @(posedge clk); @(negedge clk);
    #1;
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
                                     input logic [4:0] rs, input logic [11:0] imm,
                                     input logic [3:0] sub);
    return {op, rt, rs, imm, sub};
  endfunction

  task automatic run_case(input int c, input bit inpl);
    logic [4:0] rs, rt;
    logic [3:0][31:0] sv, ov, ev;
    string tg [4];
    logic [11:0] imm;
    logic [2:0] s3;
    logic [63:0] d;
    bit has6;
    logic ill;
    imm = 12'(c);
    rs = 5'(((c * 3) % 16) * 2);
    rt = inpl ? rs : 5'((((c * 3) + 5) % 16) * 2);
    for (int k = 0; k < 4; k++) begin
      sv[k] = 32'h5A00_0011 ^ (32'(c) << 8) ^ (32'(k) << 2);
      ov[k] = inpl ? sv[k] : (32'hC300_0000 ^ (32'(c) << 8) ^ 32'(k));
    end
    load(rs, {sv[1], sv[0]});
    load(rs + 5'd1, {sv[3], sv[2]});
    if (!inpl) begin
      load(rt, {ov[1], ov[0]});
      load(rt + 5'd1, {ov[3], ov[2]});
    end
    has6 = 1'b0;
    for (int s = 0; s < 4; s++) begin
      s3 = imm[(3 - s) * 3 +: 3];
      if (s3 < 3'd4) begin ev[s] = sv[s3[1:0]]; tg[s] = "R2 lane select"; end
      else if (s3 == 3'd4) begin ev[s] = 32'd0; tg[s] = "R3 const zero"; end
      else if (s3 == 3'd5) begin ev[s] = 32'd1; tg[s] = "R3 const one"; end
      else if (s3 == 3'd7) begin
        ev[s] = inpl ? ov[s] : 32'd0;
        tg[s] = inpl ? "R4 keep" : "R5 zero fill";
      end else has6 = 1'b1;
    end
    if (has6) begin
      ev = ov;
      for (int s = 0; s < 4; s++) tg[s] = "R8 reserved no write";
    end
    // odd immediates use the float sub-opcode: same result expected (R9)
    issue(mk(6'd22, rt, rs, imm, c[0] ? 4'b1011 : 4'b0011), ill);
    chk(has6 ? "R8 illegal flag" : "R9 legal word no flag", 64'(ill), 64'(has6));
    rd(rt, d);
    chk(tg[0], 64'(d[31:0]), 64'(ev[0]));
    chk(tg[1], 64'(d[63:32]), 64'(ev[1]));
    rd(rt + 5'd1, d);
    chk(tg[2], 64'(d[31:0]), 64'(ev[2]));
    chk(tg[3], 64'(d[63:32]), 64'(ev[3]));
    if (!inpl) begin
      rd(rs, d);
      chk("R5 source kept", d, {sv[1], sv[0]});
    end
  endtask

  task automatic bad_word(input string req, input logic [31:0] w);
    logic ill;
    logic [63:0] d;
    for (int r = 0; r < 8; r++) load(5'(r), {32'hB0B0_0000 | 32'(r), 32'h0F0F_0000 | 32'(r)});
    issue(w, ill);
    chk(req, 64'(ill), 64'd1);
    for (int r = 0; r < 8; r++) begin
      rd(5'(r), d);
      chk(req, d, {32'hB0B0_0000 | 32'(r), 32'h0F0F_0000 | 32'(r)});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic ill;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 ready", 64'(issue_ready), 64'd1);
    chk("R1 illegal", 64'(illegal_o), 64'd0);
    for (int r = 0; r < 32; r++) begin
      rd(5'(r), d);
      chk("R1 reg zero", d, 64'd0);
    end
    @(negedge clk);

    // R6: load port holds off issue
    ld_en = 1'b1; ld_addr = 5'd9; ld_data = 64'h1234_5678_9ABC_DEF0;
    #1 chk("R6 ready low during load", 64'(issue_ready), 64'd0);
    @(posedge clk); @(negedge clk);
    ld_en = 1'b0;
    rd(5'd9, d);
    chk("R10 load", d, 64'h1234_5678_9ABC_DEF0);

    // main sweep: every immediate, in place and out of place
    for (int c = 0; c < 4096; c++) begin
      run_case(c, 1'b1);
      run_case(c, 1'b0);
    end

    // R7 / R9 rejected words
    bad_word("R7 odd RT", mk(6'd22, 5'd3, 5'd4, 12'o0123, 4'b0011));
    bad_word("R7 odd RS", mk(6'd22, 5'd2, 5'd5, 12'o0123, 4'b0011));
    bad_word("R9 bad subop", mk(6'd22, 5'd2, 5'd4, 12'o0123, 4'b0001));
    bad_word("R9 bad primary", mk(6'd21, 5'd2, 5'd4, 12'o0123, 4'b0011));

    // R10: load collides with pending writeback on the same register
    load(5'd10, 64'h0000_0002_0000_0001);
    load(5'd11, 64'h0000_0004_0000_0003);
    issue_valid = 1'b1; issue_insn = mk(6'd22, 5'd20, 5'd10, 12'o3210, 4'b0011);
    @(posedge clk); @(negedge clk);
    issue_valid = 1'b0;
    ld_en = 1'b1; ld_addr = 5'd20; ld_data = 64'hFEED_FACE_CAFE_BEEF;
    @(posedge clk); @(negedge clk);
    ld_en = 1'b0;
    rd(5'd20, d);
    chk("R10 load beats writeback", d, 64'hFEED_FACE_CAFE_BEEF);
    rd(5'd21, d);
    chk("R2 other half of pair", d, 64'h0000_0001_0000_0002);
    issue(mk(6'd22, 5'd10, 5'd10, 12'o7777, 4'b1011), ill);
    chk("R4 all skip no flag", 64'(ill), 64'd0);
    rd(5'd11, d);
    chk("R4 all skip keeps", d, 64'h0000_0004_0000_0003);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule